// File: doc/BRIEF.md
# Multi-register integer lane clamp

This block saturates each lane of a group of destination vectors into a window given by two bound vectors. A 32-bit instruction word selects the lane width (8, 16, 32 or 64 bits), signed or unsigned comparison, and a group of either two or four destination registers. The same lower and upper bound vectors serve every register in the group. For each lane, the result is first raised to at least the lower bound and then cut down to at most the upper bound.

The caller presents the instruction, the group of destination vectors, the bounds and a valid strobe in one cycle. One cycle later, the updated group appears on a registered output together with an output-valid strobe and a decode-valid flag. If the word does not describe a legal clamp, the flag is low and every destination vector comes back unchanged. The vector length is a parameter and must be a multiple of 64 bits.

Top module: `lane_clamp_group`

## Requirements
- R1: Instruction bits [23:22] give the lane width: 0 selects 8-bit lanes, 1 selects 16-bit, 2 selects 32-bit and 3 selects 64-bit.
- R2: Each lane result is min(max(d, lo), hi) for lane value d, lower bound lo and upper bound hi. When lo is greater than hi, the result is hi.
- R3: Instruction bit 0 set to 0 makes every comparison signed (two's complement). Set to 1, it makes every comparison unsigned.
- R4: Opcode bits [15:10] = 110001 clamp registers 0 and 1 of the group, and registers 2 and 3 come out unchanged. Opcode bits [15:10] = 110011 clamp all four registers.
- R5: Lane e of every register in the group is clamped against lane e of the same two bound vectors.
- R6: In the four-register form, instruction bit 1 must be 0. If it is 1, the word is rejected.
- R7: A word is accepted only when bits [31:24] = 11000001 and bit 21 = 1. The register-number fields [20:16], [9:5] and [4:2] have no effect on the result.
- R8: When a word is rejected, dec_ok is low and all destination vectors come out equal to their inputs.
- R9: out_valid is high exactly one cycle after in_valid. dst_out and dec_ok are registered and update only on a strobed cycle. Reset clears out_valid, dec_ok and dst_out.
- R10: Lanes are numbered from the least significant end, so lane e of width W sits in bits [e*W+W-1 : e*W] of its register. Register g of the group sits in dst_in/dst_out bits [g*VLEN+VLEN-1 : g*VLEN].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe for instruction and operands |
| insn | input | 32 | Instruction word |
| dst_in | input | 4*VLEN | Group of four destination vectors, register 0 in the low bits |
| lo_bound | input | VLEN | Lower-bound vector |
| hi_bound | input | VLEN | Upper-bound vector |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| dec_ok | output | 1 | High when the captured word was a legal clamp |
| dst_out | output | 4*VLEN | Updated destination group |

## Verification
Every result is due at the first falling edge after the rising edge that captured its strobe, which is one cycle after the stimulus. The driver sets the inputs on a falling edge and queues the expected group and flag. The monitor checks only on falling edges where out_valid is high, and pops entries in order, so back-to-back strobes line up with their own results. After the last stimulus, the bench checks that the queue has drained and that out_valid has dropped.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_S = 2'd2,
    SZ_D = 2'd3
  } lane_sz_e;

  typedef struct packed {
    logic     ok;
    logic     quad;
    logic     uns;
    lane_sz_e sz;
  } clamp_op_t;

  localparam logic [7:0] FRAME_TOP = 8'b1100_0001;
  localparam logic [5:0] OPC_PAIR  = 6'b110001;
  localparam logic [5:0] OPC_QUAD  = 6'b110011;
  localparam int         GRP_MAX   = 4;
endpackage

// File: rtl/clamp_decode.sv
module clamp_decode
  import clamp_pkg::*;
(
  input  logic [31:0] insn,
  output clamp_op_t   op
);
  logic frame_ok, pair_op, quad_op;
  logic unused_regs;

  assign frame_ok = (insn[31:24] == FRAME_TOP) && insn[21];
  assign pair_op  = (insn[15:10] == OPC_PAIR);
  assign quad_op  = (insn[15:10] == OPC_QUAD);

  assign op.ok   = frame_ok && (pair_op || (quad_op && !insn[1]));
  assign op.quad = quad_op;
  assign op.uns  = insn[0];
  assign op.sz   = lane_sz_e'(insn[23:22]);

  // register numbers are resolved outside this block
  assign unused_regs = ^{insn[20:16], insn[9:2]};

  always_comb begin
    if (op.ok) begin
      p_frame_r7: assert (insn[31:24] == 8'hC1 && insn[21] == 1'b1);
    end
    if (op.ok && op.quad) begin
      p_quad_align_r6: assert (insn[1] == 1'b0);
    end
  end
endmodule

// File: rtl/clamp_lane.sv
module clamp_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] d,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic         uns,
  output logic [W-1:0] r
);
  // flipping the sign bit turns a signed order into an unsigned one
  logic [W-1:0] flip, df, lf, hf, t, tf;

  assign flip = {~uns, {(W-1){1'b0}}};
  assign df   = d ^ flip;
  assign lf   = lo ^ flip;
  assign hf   = hi ^ flip;
  assign t    = (df > lf) ? d : lo;
  assign tf   = t ^ flip;
  assign r    = (tf < hf) ? t : hi;

  always_comb begin : chk
    logic [W-1:0] rf;
    rf = r ^ flip;
    if (lf <= hf) begin
      p_in_bounds_r2: assert (rf >= lf && rf <= hf);
    end else begin
      p_cross_upper_r2: assert (r == hi);
    end
  end
endmodule

// File: rtl/clamp_vreg.sv
module clamp_vreg
  import clamp_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic [VLEN-1:0] d,
  input  logic [VLEN-1:0] lo,
  input  logic [VLEN-1:0] hi,
  input  lane_sz_e        sz,
  input  logic            uns,
  output logic [VLEN-1:0] r
);
  logic [VLEN-1:0] by_sz [4];

  for (genvar s = 0; s < 4; s++) begin : g_sz
    localparam int W     = 8 << s;
    localparam int LANES = VLEN / W;
    logic [VLEN-1:0] v;
    for (genvar e = 0; e < LANES; e++) begin : g_lane
      clamp_lane #(.W(W)) u_lane (
        .d  (d[e*W +: W]),
        .lo (lo[e*W +: W]),
        .hi (hi[e*W +: W]),
        .uns(uns),
        .r  (v[e*W +: W])
      );
    end
    assign by_sz[s] = v;
  end

  always_comb begin
    case (sz)
      SZ_B:    r = by_sz[0];
      SZ_H:    r = by_sz[1];
      SZ_S:    r = by_sz[2];
      default: r = by_sz[3];
    endcase
  end
endmodule

// File: rtl/lane_clamp_group.sv
module lane_clamp_group
  import clamp_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [31:0]             insn,
  input  logic [GRP_MAX*VLEN-1:0] dst_in,
  input  logic [VLEN-1:0]         lo_bound,
  input  logic [VLEN-1:0]         hi_bound,
  output logic                    out_valid,
  output logic                    dec_ok,
  output logic [GRP_MAX*VLEN-1:0] dst_out
);
  localparam int BUS = GRP_MAX * VLEN;

  clamp_op_t      op;
  logic [BUS-1:0] nxt;

  clamp_decode u_dec (
    .insn(insn),
    .op  (op)
  );

  for (genvar g = 0; g < GRP_MAX; g++) begin : g_reg
    logic [VLEN-1:0] clamped;
    logic            active;

    clamp_vreg #(.VLEN(VLEN)) u_vreg (
      .d  (dst_in[g*VLEN +: VLEN]),
      .lo (lo_bound),
      .hi (hi_bound),
      .sz (op.sz),
      .uns(op.uns),
      .r  (clamped)
    );

    assign active = op.ok && ((g < 2) || op.quad);
    assign nxt[g*VLEN +: VLEN] = active ? clamped : dst_in[g*VLEN +: VLEN];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dec_ok    <= 1'b0;
      dst_out   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dec_ok  <= op.ok;
        dst_out <= nxt;
      end
    end
  end

  p_valid_lat_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_reject_passthru_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !dec_ok) |-> (dst_out == $past(dst_in)));

  p_pair_upper_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && dec_ok && !$past(insn[11])) |->
      (dst_out[BUS-1:2*VLEN] == $past(dst_in[BUS-1:2*VLEN])));
endmodule

// File: tb/tb_lane_clamp_group.sv
`timescale 1ns/1ps
module tb_lane_clamp_group;
  localparam int V   = 128;
  localparam int BUS = 4 * V;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [31:0]    insn = '0;
  logic [BUS-1:0] dst_in = '0;
  logic [V-1:0]   lo_bound = '0;
  logic [V-1:0]   hi_bound = '0;
  logic           out_valid, dec_ok;
  logic [BUS-1:0] dst_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [BUS-1:0] d;
    logic           ok;
    string          tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  lane_clamp_group #(.VLEN(V)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .dst_in(dst_in), .lo_bound(lo_bound), .hi_bound(hi_bound),
    .out_valid(out_valid), .dec_ok(dec_ok), .dst_out(dst_out)
  );

  function automatic [31:0] mk(input logic [1:0] sz, input bit quad, input bit uns);
    return {8'hC1, sz, 1'b1, 5'd7, (quad ? 6'b110011 : 6'b110001), 5'd3, 4'b0100, uns};
  endfunction

  function automatic logic [BUS-1:0] rnd_bus();
    logic [BUS-1:0] x = '0;
    for (int k = 0; k < BUS / 32; k++) x = (x << 32) | BUS'($urandom);
    return x;
  endfunction

  // independent reference built directly from the requirements
  function automatic void model(input logic [31:0] i, input logic [BUS-1:0] d,
                                input logic [V-1:0] lo, input logic [V-1:0] hi,
                                output logic [BUS-1:0] r, output logic ok);
    int w, nreg;
    logic [63:0] mask;
    ok = (i[31:24] == 8'hC1) && i[21] &&
         ((i[15:10] == 6'b110001) || ((i[15:10] == 6'b110011) && !i[1]));
    r = d;
    if (!ok) return;
    w    = 8 << i[23:22];
    nreg = i[11] ? 4 : 2;
    mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    for (int g = 0; g < nreg; g++) begin
      for (int e = 0; e < V / w; e++) begin
        int pos;
        logic [63:0] x, a, b, t, res;
        pos = g * V + e * w;
        x = 64'(d >> pos) & mask;
        a = 64'(lo >> (e * w)) & mask;
        b = 64'(hi >> (e * w)) & mask;
        if (!i[0]) begin
          if (x[w-1]) x = x | ~mask;
          if (a[w-1]) a = a | ~mask;
          if (b[w-1]) b = b | ~mask;
          t   = ($signed(x) > $signed(a)) ? x : a;
          res = ($signed(t) < $signed(b)) ? t : b;
        end else begin
          t   = (x > a) ? x : a;
          res = (t < b) ? t : b;
        end
        res = res & mask;
        r = (r & ~(BUS'(mask) << pos)) | (BUS'(res) << pos);
      end
    end
  endfunction

  task automatic drive(input logic [31:0] i, input logic [BUS-1:0] d,
                       input logic [V-1:0] lo, input logic [V-1:0] hi,
                       input logic [BUS-1:0] ed, input logic eok, input string tag);
    exp_t x;
    @(negedge clk);
    insn = i; dst_in = d; lo_bound = lo; hi_bound = hi; in_valid = 1'b1;
    x.d = ed; x.ok = eok; x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic drive_m(input logic [31:0] i, input logic [BUS-1:0] d,
                         input logic [V-1:0] lo, input logic [V-1:0] hi, input string tag);
    logic [BUS-1:0] ed;
    logic eok;
    model(i, d, lo, hi, ed, eok);
    drive(i, d, lo, hi, ed, eok, tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: results are due one cycle after their strobe
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R9: out_valid with no pending stimulus (actual 1, expected 0)");
      end else begin
        exp_t x;
        x = sb.pop_front();
        if (dst_out !== x.d || dec_ok !== x.ok) begin
          fails++;
          $display("FAIL %s: dec_ok=%0b dst_out=%h expected dec_ok=%0b dst_out=%h",
                   x.tag, dec_ok, dst_out, x.ok, x.d);
        end
      end
    end
  end

  initial begin
    logic [BUS-1:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (out_valid !== 1'b0 || dec_ok !== 1'b0 || dst_out !== '0) begin
      fails++;
      $display("FAIL R9: reset state ov=%0b ok=%0b out=%h expected 0 0 0",
               out_valid, dec_ok, dst_out);
    end

    // R3: signed vs unsigned on 0x80 lanes within [0x00,0x7F]
    d = {64{8'h80}};
    drive(mk(2'd0, 1'b0, 1'b0), d, {16{8'h00}}, {16{8'h7F}},
          {d[BUS-1:2*V], {32{8'h00}}}, 1'b1, "R3 signed byte");
    drive(mk(2'd0, 1'b0, 1'b1), d, {16{8'h00}}, {16{8'h7F}},
          {d[BUS-1:2*V], {32{8'h7F}}}, 1'b1, "R3 unsigned byte");
    // R2: crossed bounds give the upper bound; R4 upper pair untouched
    d = rnd_bus();
    drive(mk(2'd0, 1'b0, 1'b1), d, {16{8'h50}}, {16{8'h10}},
          {d[BUS-1:2*V], {32{8'h10}}}, 1'b1, "R2 crossed bounds");
    // R10: lane 0 is the least significant halfword
    drive(mk(2'd1, 1'b0, 1'b1), BUS'(16'hFFFF), '0,
          {{7{16'hFFFF}}, 16'h1234}, BUS'(16'h1234), 1'b1, "R10 lane order");
    // R1: 64-bit lane width
    drive(mk(2'd3, 1'b0, 1'b0), BUS'(64'h0000_0001_0000_0000), '0,
          {64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF},
          BUS'(64'hFFFF_FFFF), 1'b1, "R1 dword width");
    // R4/R5: four-register form, shared bounds
    d = {4{{8{16'h9000}}}};
    drive(mk(2'd1, 1'b1, 1'b1), d, {8{16'hA000}}, {8{16'hB000}},
          {4{{8{16'hA000}}}}, 1'b1, "R5 quad shared bounds");
    idle(2);

    // R6/R7/R8: rejected words pass everything through
    d = rnd_bus();
    drive(mk(2'd0, 1'b1, 1'b0) | 32'h2, d, '0, '0, d, 1'b0, "R6 quad bit1 set");
    drive({8'hC0, mk(2'd0, 1'b0, 1'b0) & 32'h00FF_FFFF} , d, '0, '0, d, 1'b0, "R7 bad top byte");
    drive(mk(2'd2, 1'b0, 1'b0) & ~32'h0020_0000, d, '0, '0, d, 1'b0, "R7 bit21 clear");
    drive((mk(2'd2, 1'b0, 1'b0) & ~32'h0000_FC00) | 32'h0000_C000, d, '0, '0, d, 1'b0,
          "R8 other opcode");
    // R7: register fields have no effect
    drive_m(mk(2'd2, 1'b1, 1'b0) ^ 32'h001F_03FC, rnd_bus(), rnd_bus()[V-1:0],
            rnd_bus()[V-1:0], "R7 register fields ignored");
    idle(1);

    // R1 R2 R3 R4 R5: random operands over all forms, back to back
    for (int k = 0; k < 32; k++) begin
      drive_m(mk(2'(k % 4), bit'((k / 4) % 2), bit'((k / 8) % 2)), rnd_bus(),
              rnd_bus()[V-1:0], rnd_bus()[V-1:0], "R1 R2 R3 R4 R5 random");
    end
    idle(4);

    checks++;
    if (sb.size() != 0 || out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R9: pending=%0d out_valid=%0b expected 0 0", sb.size(), out_valid);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule